// File: doc/BRIEF.md
# Multi-source reset controller

This block merges the reset requests of a small microcontroller into the internal reset outputs. Four sources feed it: two supply comparator flags (a primary and a secondary low-voltage monitor), a watchdog underflow pulse gated by a reset-on-underflow enable, and a software reset bit written by the CPU. The comparator flags are asynchronous and pass through a two-flop synchronizer on the free-running low-speed oscillator clock, which clocks the whole block.

Any active source drives the full reset `sys_rst_o`, which goes to the pins, the CPU and the registers. Only the primary monitor (and the power-on reset, which the block treats as a primary event) also drives `keep_rst_o`, which clears the retained register group. The secondary monitor, the watchdog and the software bit leave that group alone. The primary reset is held for 32 low-speed clocks after its flag clears. The watchdog and software resets last a fixed number of cycles. When the full reset releases, the block raises a one-cycle vector-fetch request. While reset is active it forces the CPU clock select to the low-speed oscillator divided by 8. A cause register records which source caused the last reset. Memory contents are outside this block and no source clears them.

Top module: `rst_hub`

## Requirements
- R1: A 1 on `vmon1_low_i` raises `sys_rst_o` and `keep_rst_o` two clock edges after it is applied, and not after only one edge. The asynchronous reset `rst_ni` also holds both outputs at 1.
- R2: After `vmon1_low_i` returns to 0, `keep_rst_o` stays 1 through the 33rd edge and falls at the 34th: two synchronizer edges, then 32 counted clocks. After `rst_ni` is released, it falls at the 32nd edge.
- R3: A 1 on `vmon2_low_i` raises `sys_rst_o` two edges after it is applied. `sys_rst_o` falls two edges after the flag returns to 0, unless another source still holds it.
- R4: With `wdt_rst_en_i`=1, an edge that samples `wdt_uflow_i`=1 raises `sys_rst_o` for exactly 4 cycles. With `wdt_rst_en_i`=0 the underflow has no effect on any output.
- R5: Writing 1 to the software bit outside reset sets `sw_rst_bit_o` at the next edge. At the edge after that, the bit clears itself and `sys_rst_o` rises for 4 cycles. Writing 0, or writing while `sys_rst_o` is 1, changes nothing.
- R6: `clk_sel_o` resets to 2'b01, the code for the low-speed oscillator divided by 8. It becomes 2'b01 one edge after any cycle with `sys_rst_o`=1. CPU writes to it take effect only while `sys_rst_o`=0.
- R7: `keep_rst_o` is 1 only for the primary monitor and power-on. The secondary, watchdog and software sources never raise it.
- R8: `vec_fetch_o` is a single-cycle pulse in the first cycle with `sys_rst_o`=0 after a cycle with `sys_rst_o`=1.
- R9: `cause_o` uses bit 0 for the primary monitor, bit 1 for the secondary, bit 2 for the watchdog and bit 3 for the software bit. A reset that starts from idle replaces the whole register. A source joining a reset already in progress ORs its bit in. While the primary monitor is active, the register reads 4'b0001 and nothing else. The register reads 4'b0001 after power-on.
- R10: A cause write outside reset clears every bit written as 0 and keeps every bit written as 1. A cause write during reset is ignored.
- R11: When sources overlap, `sys_rst_o` stays 1 until the last of them releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running low-speed oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| vmon1_low_i | input | 1 | Primary supply comparator flag (asynchronous), 1 = supply at or below threshold |
| vmon2_low_i | input | 1 | Secondary supply comparator flag (asynchronous), 1 = supply at or below threshold |
| wdt_uflow_i | input | 1 | Watchdog underflow pulse |
| wdt_rst_en_i | input | 1 | Reset-on-underflow enable |
| sw_rst_wr_i | input | 1 | CPU write strobe for the software reset bit |
| sw_rst_wdata_i | input | 1 | Value written to the software reset bit |
| cause_wr_i | input | 1 | CPU write strobe for the cause register |
| cause_wdata_i | input | 4 | Cause write data, 0 bits clear |
| clk_sel_wr_i | input | 1 | CPU write strobe for the clock select |
| clk_sel_wdata_i | input | 2 | Clock select write data |
| sys_rst_o | output | 1 | Full reset for pins, CPU and registers |
| keep_rst_o | output | 1 | Reset for the retained register group |
| vec_fetch_o | output | 1 | One-cycle request to fetch the reset vector |
| clk_sel_o | output | 2 | CPU clock select, 2'b01 = low-speed divided by 8 |
| cause_o | output | 4 | Reset cause, one bit per source |
| sw_rst_bit_o | output | 1 | Software reset bit readback |

## Verification
The bench drives every input at the falling edge and samples at the next falling edge, so each check sits an exact number of rising edges after its stimulus. Comparator flags show up two edges after they are applied. The primary release is due at the 34th edge after the flag drops, and the power-on release at the 32nd edge. A watchdog pulse holds reset for edges 1 to 4 after it is sampled. A software write holds reset for edges 2 to 5, and the cause register and clock select settle one edge after reset is seen. Each check samples one cycle before and one cycle at the due edge, and the random watchdog phase tracks a remaining-cycle count per edge in a bench function.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_VM1 = 0;
  localparam int SRC_VM2 = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_SW  = 3;

  typedef logic [1:0] clk_sel_t;
  localparam clk_sel_t CLK_LS_DIV8 = 2'b01;
  localparam logic [NSRC-1:0] CAUSE_VM1 = NSRC'(1) << SRC_VM1;
endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/rst_hub_brownout.sv
module rst_hub_brownout #(
  parameter int RELEASE_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic hold_o
);
  localparam int CNT_W = (RELEASE_CYC > 2) ? $clog2(RELEASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (low_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int RELEASE_CYC = 32,
  parameter int PULSE_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vmon1_low_i,
  input  logic            vmon2_low_i,
  input  logic            wdt_uflow_i,
  input  logic            wdt_rst_en_i,
  input  logic            sw_rst_wr_i,
  input  logic            sw_rst_wdata_i,
  input  logic            cause_wr_i,
  input  logic [NSRC-1:0] cause_wdata_i,
  input  logic            clk_sel_wr_i,
  input  logic [1:0]      clk_sel_wdata_i,
  output logic            sys_rst_o,
  output logic            keep_rst_o,
  output logic            vec_fetch_o,
  output logic [1:0]      clk_sel_o,
  output logic [NSRC-1:0] cause_o,
  output logic            sw_rst_bit_o
);
  logic [1:0]      vm_s;
  logic            vm1_hold;
  logic            pulse_act;
  logic            wdt_trig;
  logic            prim;
  logic            sys_rst;
  logic            rst_d_q;
  logic            sw_bit_q;
  clk_sel_t        clk_sel_q;
  logic [NSRC-1:0] cause_q;
  logic [NSRC-1:0] srcs;

  rst_hub_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vmon2_low_i, vmon1_low_i}),
    .q_o   (vm_s)
  );

  rst_hub_brownout #(.RELEASE_CYC(RELEASE_CYC)) u_brownout (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .low_i (vm_s[0]),
    .hold_o(vm1_hold)
  );

  assign wdt_trig = wdt_uflow_i & wdt_rst_en_i;

  rst_hub_stretch #(.HOLD_CYC(PULSE_CYC)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (wdt_trig | sw_bit_q),
    .active_o(pulse_act)
  );

  assign prim    = vm_s[0] | vm1_hold;
  assign sys_rst = prim | vm_s[1] | pulse_act;

  always_comb begin
    srcs          = '0;
    srcs[SRC_VM1] = vm_s[0];
    srcs[SRC_VM2] = vm_s[1];
    srcs[SRC_WDT] = wdt_trig;
    srcs[SRC_SW]  = sw_bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_d_q   <= 1'b1;
      sw_bit_q  <= 1'b0;
      clk_sel_q <= CLK_LS_DIV8;
      cause_q   <= CAUSE_VM1;
    end else begin
      rst_d_q <= sys_rst;
      // self-clear on the edge that launches the stretched reset
      if (sw_bit_q)                                       sw_bit_q <= 1'b0;
      else if (sw_rst_wr_i && sw_rst_wdata_i && !sys_rst) sw_bit_q <= 1'b1;

      if (sys_rst)           clk_sel_q <= CLK_LS_DIV8;
      else if (clk_sel_wr_i) clk_sel_q <= clk_sel_wdata_i;

      // primary monitor wins; fresh reset replaces, overlapping one accumulates
      if (prim)                           cause_q <= CAUSE_VM1;
      else if (srcs != '0)                cause_q <= rst_d_q ? (cause_q | srcs) : srcs;
      else if (cause_wr_i && !sys_rst)    cause_q <= cause_q & cause_wdata_i;
    end
  end

  assign sys_rst_o    = sys_rst;
  assign keep_rst_o   = prim;
  assign vec_fetch_o  = rst_d_q & ~sys_rst;
  assign clk_sel_o    = clk_sel_q;
  assign cause_o      = cause_q;
  assign sw_rst_bit_o = sw_bit_q;
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk
  import rst_hub_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wdt_uflow_i,
  input logic            wdt_rst_en_i,
  input logic            sys_rst_o,
  input logic            keep_rst_o,
  input logic            vec_fetch_o,
  input logic [1:0]      clk_sel_o,
  input logic [NSRC-1:0] cause_o,
  input logic            sw_rst_bit_o
);
  AST_KEEP_IN_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_rst_o |-> sys_rst_o); // R7
  AST_CLK_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (clk_sel_o == CLK_LS_DIV8)); // R6
  AST_VEC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |=> !vec_fetch_o); // R8
  AST_VEC_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |-> (!sys_rst_o && $past(sys_rst_o))); // R8
  AST_SW_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_bit_o |=> (!sw_rst_bit_o && sys_rst_o)); // R5
  AST_WDT_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_uflow_i && wdt_rst_en_i) |=> sys_rst_o); // R4
  AST_CAUSE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_rst_o && $past(keep_rst_o)) |-> (cause_o == 4'b0001)); // R9
endmodule

bind rst_hub rst_hub_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wdt_uflow_i (wdt_uflow_i),
  .wdt_rst_en_i(wdt_rst_en_i),
  .sys_rst_o   (sys_rst_o),
  .keep_rst_o  (keep_rst_o),
  .vec_fetch_o (vec_fetch_o),
  .clk_sel_o   (clk_sel_o),
  .cause_o     (cause_o),
  .sw_rst_bit_o(sw_rst_bit_o)
);

// File: tb/rst_hub_bench.sv
`timescale 1ns/1ps
module rst_hub_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vmon1_low = 1'b0, vmon2_low = 1'b0;
  logic       wdt_uflow = 1'b0, wdt_en = 1'b0;
  logic       sw_wr = 1'b0, sw_wdata = 1'b0;
  logic       cause_wr = 1'b0;
  logic [3:0] cause_wdata = 4'h0;
  logic       clk_sel_wr = 1'b0;
  logic [1:0] clk_sel_wdata = 2'b00;
  logic       sys_rst, keep_rst, vec_fetch, sw_bit;
  logic [1:0] clk_sel;
  logic [3:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rst_hub u_rst_hub (
    .clk_i(clk), .rst_ni(rst_ni),
    .vmon1_low_i(vmon1_low), .vmon2_low_i(vmon2_low),
    .wdt_uflow_i(wdt_uflow), .wdt_rst_en_i(wdt_en),
    .sw_rst_wr_i(sw_wr), .sw_rst_wdata_i(sw_wdata),
    .cause_wr_i(cause_wr), .cause_wdata_i(cause_wdata),
    .clk_sel_wr_i(clk_sel_wr), .clk_sel_wdata_i(clk_sel_wdata),
    .sys_rst_o(sys_rst), .keep_rst_o(keep_rst), .vec_fetch_o(vec_fetch),
    .clk_sel_o(clk_sel), .cause_o(cause), .sw_rst_bit_o(sw_bit)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // remaining stretched-reset cycles after one edge
  function automatic int next_rem(int rem, logic trig);
    if (trig) return 4;
    if (rem > 0) return rem - 1;
    return 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rem;
    void'($urandom(32'h5EED_0042));
    tick(3);
    check("R1 sys in por", 32'(sys_rst), 1);
    check("R1 keep in por", 32'(keep_rst), 1);
    check("R6 clk_sel reset", 32'(clk_sel), 32'h1);
    check("R9 cause reset", 32'(cause), 32'h1);
    rst_ni = 1'b1;
    tick(31);
    check("R2 por hold at 31", 32'(sys_rst), 1);
    tick(1);
    check("R2 por release at 32", 32'(keep_rst), 0);
    check("R2 sys release", 32'(sys_rst), 0);
    check("R8 vec pulse", 32'(vec_fetch), 1);
    tick(1);
    check("R8 vec single", 32'(vec_fetch), 0);

    clk_sel_wr = 1'b1; clk_sel_wdata = 2'b10;
    tick(1);
    clk_sel_wr = 1'b0;
    check("R6 clk_sel write idle", 32'(clk_sel), 32'h2);

    sw_wr = 1'b1; sw_wdata = 1'b0;
    tick(1);
    sw_wr = 1'b0;
    tick(5);
    check("R5 write 0 no bit", 32'(sw_bit), 0);
    check("R5 write 0 no reset", 32'(sys_rst), 0);

    wdt_uflow = 1'b1; wdt_en = 1'b0;
    tick(1);
    wdt_uflow = 1'b0;
    check("R4 disabled no reset", 32'(sys_rst), 0);
    check("R4 disabled cause kept", 32'(cause), 32'h1);

    cause_wr = 1'b1; cause_wdata = 4'b1110;
    tick(1);
    cause_wr = 1'b0;
    check("R10 clear by 0", 32'(cause), 32'h0);

    wdt_uflow = 1'b1; wdt_en = 1'b1;
    tick(1);
    wdt_uflow = 1'b0;
    check("R4 wdt reset", 32'(sys_rst), 1);
    check("R9 cause wdt", 32'(cause), 32'h4);
    check("R7 wdt no keep", 32'(keep_rst), 0);
    tick(1);
    check("R6 forced div8", 32'(clk_sel), 32'h1);
    tick(2);
    check("R4 hold 4th", 32'(sys_rst), 1);
    tick(1);
    check("R4 release 5th", 32'(sys_rst), 0);
    check("R8 vec after wdt", 32'(vec_fetch), 1);

    cause_wr = 1'b1; cause_wdata = 4'b1111;
    tick(1);
    check("R10 keep by 1", 32'(cause), 32'h4);
    cause_wdata = 4'b1011;
    tick(1);
    cause_wr = 1'b0;
    check("R10 clear bit2", 32'(cause), 32'h0);

    sw_wr = 1'b1; sw_wdata = 1'b1;
    tick(1);
    sw_wr = 1'b0;
    check("R5 bit set", 32'(sw_bit), 1);
    check("R5 not yet reset", 32'(sys_rst), 0);
    tick(1);
    check("R5 bit self clear", 32'(sw_bit), 0);
    check("R5 sw reset", 32'(sys_rst), 1);
    check("R9 cause sw", 32'(cause), 32'h8);
    check("R7 sw no keep", 32'(keep_rst), 0);
    tick(3);
    check("R5 hold", 32'(sys_rst), 1);
    tick(1);
    check("R5 release", 32'(sys_rst), 0);

    vmon2_low = 1'b1;
    tick(1);
    check("R3 sync delay", 32'(sys_rst), 0);
    tick(1);
    check("R3 v2 reset", 32'(sys_rst), 1);
    check("R7 v2 no keep", 32'(keep_rst), 0);
    tick(1);
    check("R9 cause v2", 32'(cause), 32'h2);
    sw_wr = 1'b1; sw_wdata = 1'b1;
    cause_wr = 1'b1; cause_wdata = 4'h0;
    clk_sel_wr = 1'b1; clk_sel_wdata = 2'b10;
    tick(1);
    sw_wr = 1'b0; cause_wr = 1'b0; clk_sel_wr = 1'b0;
    check("R5 write in reset ignored", 32'(sw_bit), 0);
    check("R10 write in reset ignored", 32'(cause), 32'h2);
    check("R6 write in reset ignored", 32'(clk_sel), 32'h1);
    tick(5);
    wdt_uflow = 1'b1;
    tick(1);
    wdt_uflow = 1'b0;
    check("R9 overlap or", 32'(cause), 32'h6);
    tick(6);
    vmon2_low = 1'b0;
    tick(1);
    check("R3 release delay", 32'(sys_rst), 1);
    tick(1);
    check("R3 release", 32'(sys_rst), 0);
    check("R8 vec after v2", 32'(vec_fetch), 1);
    tick(3);

    vmon2_low = 1'b1;
    tick(5);
    wdt_uflow = 1'b1; vmon2_low = 1'b0;
    tick(1);
    wdt_uflow = 1'b0;
    tick(2);
    check("R11 held by wdt", 32'(sys_rst), 1);
    tick(1);
    check("R11 held last", 32'(sys_rst), 1);
    tick(1);
    check("R11 all released", 32'(sys_rst), 0);
    tick(3);

    vmon1_low = 1'b1;
    tick(1);
    check("R1 sync delay", 32'(keep_rst), 0);
    tick(1);
    check("R1 keep", 32'(keep_rst), 1);
    check("R1 sys", 32'(sys_rst), 1);
    vmon2_low = 1'b1;
    tick(1);
    wdt_uflow = 1'b1;
    tick(1);
    wdt_uflow = 1'b0;
    check("R9 primary priority", 32'(cause), 32'h1);
    vmon1_low = 1'b0;
    tick(33);
    check("R2 hold at 33", 32'(keep_rst), 1);
    tick(1);
    check("R2 release at 34", 32'(keep_rst), 0);
    check("R11 v2 still holds", 32'(sys_rst), 1);
    vmon2_low = 1'b0;
    tick(2);
    check("R11 released", 32'(sys_rst), 0);
    tick(2);

    rem = 0;
    for (int i = 0; i < 300; i++) begin
      logic u, e;
      u = ($urandom % 5) == 0;
      e = $urandom % 2;
      wdt_uflow = u; wdt_en = e;
      tick(1);
      rem = next_rem(rem, u & e);
      check("R4 random wdt", 32'(sys_rst), 32'(rem != 0));
      check("R7 random keep", 32'(keep_rst), 0);
    end
    wdt_uflow = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule